// File: doc/BRIEF.md
# Wrap-Corrected Time Difference Unit

This block takes pairs of calibrated timestamps and returns the time between them. Typical pairs are a trailing edge and a leading edge, which give a time-over-threshold, or a stop hit and a reference hit. Each timestamp is made from a coarse cycle count and a fine offset, and the coarse counter rolls over. A stop taken after a roll-over can therefore look earlier than its start. The unit repairs this by adding whole wrap periods to a negative raw difference until it is no longer negative.

Each input pair carries a select bit that picks the roll-over length for that pair: a short wrap of 2048 cycles or a long wrap of 8192 cycles. This lets channels whose counters roll over at different counts share one datapath. Both the input and the output use valid/ready handshakes. A pair that needs no correction moves through in one cycle. Each correction step costs one more cycle, and the input side is held off while a correction is running. The number of correction steps is capped. A result that is still negative when the cap is reached is delivered with an error flag.

Top module: `wrap_diff`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: If `in_stop - in_start` is non-negative, `out_diff` equals that difference and `out_err` is 0. `out_valid` rises in the first cycle after the pair is accepted.
- R3: If the raw difference is negative, one wrap period is added repeatedly until the value is non-negative. The period is 2048·CLK_PS picoseconds when `in_long_wrap` is 0, and 8192·CLK_PS when it is 1. A value that reaches exactly 0 needs no further addition.
- R4: Each added period costs one cycle, so a pair that needs k additions is presented k+1 cycles after it is accepted. `in_ready` stays 0 while a correction is running.
- R5: At most 4 periods are added. If the value is still negative after that, `out_err` is 1 and `out_diff` is the raw difference plus 4 periods.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_diff` and `out_err` stay stable and `in_ready` is 0.
- R7: With `out_ready` held at 1, pairs that need no correction are accepted on every cycle, and each result appears one cycle after its pair.
- R8: The wrap select and the timestamps are captured when a pair is accepted. Changing them during a correction has no effect on that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pair valid |
| in_ready | output | 1 | Unit can take a pair |
| in_start | input | W | Earlier timestamp, signed ps |
| in_stop | input | W | Later timestamp, signed ps |
| in_long_wrap | input | 1 | 0: 2048-cycle wrap, 1: 8192-cycle wrap |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_diff | output | W | Corrected difference, signed ps |
| out_err | output | 1 | Still negative after the maximum number of corrections |

## Verification
The bench sweeps raw differences from five periods below zero to one period above zero, for both wrap lengths. At each multiple it uses offsets of zero, one, half a period and one less than a period. The zero offsets hit the exact-zero stopping point. The one-less offsets tell an off-by-one in the stop test apart from a correct result. The five-period cases separate the capped error path from a normal correction. Every pair is also checked for latency equal to the number of additions plus one, is held under backpressure, and has its select and data inputs disturbed during correction. A streaming run of uncorrected pairs confirms one result per cycle.

// File: rtl/wrap_diff.sv
module wrap_diff #(
  parameter int W         = 32,
  parameter int CLK_PS    = 5000,
  parameter int SHORT_CYC = 2048,
  parameter int LONG_CYC  = 8192,
  parameter int MAX_ADDS  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic signed [W-1:0] in_start,
  input  logic signed [W-1:0] in_stop,
  input  logic                in_long_wrap,
  output logic                out_valid,
  input  logic                out_ready,
  output logic signed [W-1:0] out_diff,
  output logic                out_err
);
  localparam int CW = $clog2(MAX_ADDS + 1);
  localparam logic signed [W-1:0] SHORT_PS = W'(SHORT_CYC * CLK_PS);
  localparam logic signed [W-1:0] LONG_PS  = W'(LONG_CYC * CLK_PS);

  logic signed [W-1:0] acc, step, raw, nxt;
  logic [CW-1:0]       cnt;
  logic                busy, ov, err;
  logic                take_in, last;

  assign in_ready  = !busy && (!ov || out_ready);
  assign take_in   = in_valid && in_ready;
  assign raw       = in_stop - in_start;
  assign nxt       = acc + step;
  assign last      = !nxt[W-1] || (cnt == CW'(MAX_ADDS - 1));
  assign out_valid = ov;
  assign out_diff  = acc;
  assign out_err   = err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      step <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      ov   <= 1'b0;
      err  <= 1'b0;
    end else if (take_in) begin
      acc  <= raw;
      step <= in_long_wrap ? LONG_PS : SHORT_PS;
      cnt  <= '0;
      err  <= 1'b0;
      busy <= raw[W-1];
      ov   <= !raw[W-1];
    end else if (busy) begin
      acc <= nxt;
      cnt <= cnt + 1'b1;
      if (last) begin
        busy <= 1'b0;
        ov   <= 1'b1;
        err  <= nxt[W-1];
      end
    end else if (ov && out_ready) begin
      ov <= 1'b0;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !out_valid && in_ready); // R1
  AST_OK_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_err |-> !out_diff[W-1]); // R3
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready && !out_valid); // R4
  AST_ADD_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(MAX_ADDS)); // R5
  AST_ERR_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> out_diff[W-1]); // R5
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_diff) && $stable(out_err)); // R6
endmodule

// File: tb/wrap_diff_tb.sv
module wrap_diff_tb;
  localparam int W = 32;
  localparam int CLK_PS = 5000;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_long_wrap = 0, out_ready = 0;
  logic signed [W-1:0] in_start = 0, in_stop = 0;
  logic in_ready, out_valid, out_err;
  logic signed [W-1:0] out_diff;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wrap_diff #(.W(W), .CLK_PS(CLK_PS)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_start(in_start), .in_stop(in_stop), .in_long_wrap(in_long_wrap),
    .out_valid(out_valid), .out_ready(out_ready), .out_diff(out_diff), .out_err(out_err));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic one_pair(input int start, input int raw, input bit sel);
    int p, v, adds, lat;
    bit e;
    p = sel ? 8192 * CLK_PS : 2048 * CLK_PS;
    v = raw; adds = 0;
    while (v < 0 && adds < 4) begin v += p; adds++; end
    e = (v < 0);
    chk(in_ready, "R1 ready before pair", in_ready, 1);
    in_valid = 1; in_start = start; in_stop = start + raw; in_long_wrap = sel;
    @(posedge clk); @(negedge clk);
    in_valid = 0; in_long_wrap = ~sel; in_start = 12345; in_stop = -999;
    lat = 1;
    while (!out_valid && lat < 20) begin
      chk(!in_ready, "R4 ready low during correction", in_ready, 0);
      @(posedge clk); @(negedge clk); lat++;
    end
    chk(lat == adds + 1, "R4 latency", lat, adds + 1);
    chk(out_diff == v, e ? "R5 capped value" : (raw < 0 ? "R3/R8 corrected value" : "R2 value"),
        out_diff, v);
    chk(out_err == e, e ? "R5 error flag" : "R2 error flag", out_err, e);
    chk(!in_ready, "R6 ready low while stalled", in_ready, 0);
    @(posedge clk); @(negedge clk);
    chk(out_valid && out_diff == v && out_err == e, "R6 hold under stall", out_diff, v);
    out_ready = 1;
    @(posedge clk); @(negedge clk);
    out_ready = 0;
    chk(!out_valid, "R6 result consumed", out_valid, 0);
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < 150000) begin @(posedge clk); wd++; end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", wd, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!out_valid, "R1 out_valid after reset", out_valid, 0);
    chk(in_ready, "R1 in_ready after reset", in_ready, 1);

    for (int s = 0; s < 2; s++) begin
      int p;
      p = s ? 8192 * CLK_PS : 2048 * CLK_PS;
      for (int m = -5; m <= 1; m++) begin
        int offs[4];
        offs[0] = 0; offs[1] = 1; offs[2] = p / 2; offs[3] = p - 1;
        for (int k = 0; k < 4; k++)
          one_pair(1000000 + m * 13 + k, m * p + offs[k], s[0]);
      end
    end

    out_ready = 1;
    for (int i = 0; i < 8; i++) begin
      chk(in_ready, "R7 ready each cycle", in_ready, 1);
      in_valid = 1; in_start = 500 + i; in_stop = 500 + i + i * 7 + 3; in_long_wrap = i[0];
      @(posedge clk); @(negedge clk);
      chk(out_valid && out_diff == i * 7 + 3, "R7 streamed result", out_diff, i * 7 + 3);
    end
    in_valid = 0;
    @(posedge clk); @(negedge clk);
    chk(!out_valid, "R7 drain", out_valid, 0);
    out_ready = 0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule